// File: doc/BRIEF.md
# Priority-TDM Star Hub with Crossbar

This block is the central switch of a star-shaped on-chip network. Routers connect to it, and each router serves a small group of network interfaces. For every network interface, a router holds one request bit toward the hub and receives one access bit back. The hub gives the shared fabric to exactly one network interface per time slot. A slot lasts as long as one packet takes to cross the fabric. The hub then steers that router's flits through a crossbar to one destination router, or to all routers. The hub stores no packets. Every path it forms is purely combinational from the granted input to the selected outputs.

Arbitration uses a cyclic slot table together with fixed priorities per producer. Each table entry names the producer that owns that slot. When the owner is requesting at the slot boundary, it takes the slot. When the owner is not requesting, the slot goes to the requester with the highest priority. The slot table, the priorities and the active slot count are loaded through a small write port. That port only works while reset is held.

The hub has three states. `ST_IDLE` marks a slot in which nobody was granted. `ST_HEAD` covers the flit time of the header. `ST_PAYLOAD` covers the remaining flit times of the packet. On the last cycle of any slot the next state is chosen: `ST_HEAD` if the arbiter found a requester, otherwise `ST_IDLE`. In `ST_HEAD`, once the header flit time has elapsed and the slot is not yet over, the state moves to `ST_PAYLOAD`. Reset enters `ST_IDLE` with the phase counter at the last cycle of a slot. The first cycle after reset therefore decides slot 0.

Top module: `hub_top`

## Requirements
- R1: While reset is held, `access_o`, `tx_active_o` and `out_data_o` are all zero. After release, the first cycle decides the owner of slot 0, and slot 0 starts one cycle later.
- R2: A slot lasts FLITS_PER_PKT×CYC_PER_FLIT cycles, which is 3 by default. The decision for a slot is made from `req_i` in the last cycle of the preceding slot. A producer that is not requesting in that cycle is never granted. A slot with no requester leaves all outputs at zero.
- R3: If the owner named in the table entry of the next slot is requesting, that owner receives the slot, whatever the priorities of the other requesters.
- R4: If the owner is not requesting, the slot goes to the requesting producer with the highest 4-bit priority. On a tie, the lowest producer index wins. Producer p = router·NI_PER_ROUTER + interface, and it is granted by raising bit p of `access_o`. At most one bit is ever high.
- R5: The access bit stays high for every cycle of the granted slot. No request can withdraw it before the slot ends. A request that is not served stays eligible for later slots.
- R6: `out_data_o` of a routed router carries the flit of the granted router only. Data from routers without access never reaches an output, and unrouted outputs are zero.
- R7: The destination is read from bits [31:24] of the header flit. A value below ROUTERS selects that router. The path and the matching `tx_active_o` bit go high in the header cycle and stay unchanged for the payload cycles of that slot.
- R8: A destination of 0xFF routes the packet to every router, with all `tx_active_o` bits high. Any other value of ROUTERS or above routes nowhere.
- R9: Configuration writes use `cfg_kind`: 0 writes the owner at slot `cfg_addr`, 1 writes the priority of producer `cfg_addr`, and 2 writes the active slot count, clamped to 1..MAX_SLOTS. These writes take effect only while `rst_n` is low and are ignored while running. The slot index wraps from count−1 to 0.
- R10: A producer that owns S_ch evenly spaced slots out of S_total is granted at most ((S_total−1)/S_ch + 1)·t_slot + 1 cycles after its request rises, using integer division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also enables configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 slot owner, 1 priority, 2 slot count |
| cfg_addr | input | 7 | Slot index or producer index |
| cfg_data | input | 8 | Owner index, priority (low 4 bits) or slot count |
| req_i | input | 8 | Request bits, one per producer, router-major |
| access_o | output | 8 | Access bits, one per producer, at most one high |
| in_data_i | input | 128 | One 32-bit flit link from each router |
| out_data_o | output | 128 | One 32-bit flit link toward each router |
| tx_active_o | output | 4 | Transmission-state line toward each router |

## Verification
The assertions rely on four properties of the attached routers. A router keeps a request high until the hub grants it. It presents its header in the first cycle of a granted slot. It holds that header for the whole header flit time. It writes configuration only under reset. The bench drives each request from a count of pending packets, and that count falls only when a grant is issued. It places the granted producer's header only in the slot's first cycle, and it fills every link without access with random words so that leakage would show at the outputs. One write made while the hub runs checks that configuration is ignored outside reset, and a second reset with a shorter slot count checks the wrap point.

// File: rtl/hub_pkg.sv
package hub_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HEAD    = 2'd1,
        ST_PAYLOAD = 2'd2
    } hub_state_e;

    typedef enum logic [1:0] {
        CFG_OWNER = 2'd0,
        CFG_PRIO  = 2'd1,
        CFG_COUNT = 2'd2
    } cfg_kind_e;

    localparam int         DEST_W     = 8;
    localparam logic [7:0] DEST_BCAST = 8'hFF;

endpackage

// File: rtl/hub_sched.sv
module hub_sched
    import hub_pkg::*;
#(
    parameter int PROD      = 8,
    parameter int PW        = 3,
    parameter int PRIO_W    = 4,
    parameter int MAX_SLOTS = 96,
    parameter int SLOT_AW   = 7,
    parameter int CNT_W     = 7,
    parameter int CFG_AW    = 7,
    parameter int CFG_DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_kind,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [CFG_DW-1:0]        cfg_data,
    input  logic                     advance,
    output logic [PW-1:0]            nxt_owner,
    output logic [PROD*PRIO_W-1:0]   prio_flat
);

    logic [PW-1:0]      owner_q [MAX_SLOTS];
    logic [PRIO_W-1:0]  prio_q  [PROD];
    logic [CNT_W-1:0]   cnt_q;
    logic [SLOT_AW-1:0] cur_slot;
    logic [SLOT_AW-1:0] nxt_slot;
    logic               cfg_ok;

    assign cfg_ok = cfg_we && !rst_n;

    always_ff @(posedge clk) begin
        if (cfg_ok && cfg_kind == CFG_OWNER && int'(cfg_addr) < MAX_SLOTS)
            owner_q[SLOT_AW'(cfg_addr)] <= PW'(cfg_data);
        if (cfg_ok && cfg_kind == CFG_PRIO && int'(cfg_addr) < PROD)
            prio_q[PW'(cfg_addr)] <= PRIO_W'(cfg_data);
        if (cfg_ok && cfg_kind == CFG_COUNT) begin
            if (cfg_data == '0)
                cnt_q <= CNT_W'(1);
            else if (int'(cfg_data) > MAX_SLOTS)
                cnt_q <= CNT_W'(MAX_SLOTS);
            else
                cnt_q <= CNT_W'(cfg_data);
        end
    end

    always_comb begin
        if (int'(cur_slot) + 1 >= int'(cnt_q))
            nxt_slot = '0;
        else
            nxt_slot = cur_slot + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_slot <= SLOT_AW'(int'(cnt_q) - 1);
        else if (advance)
            cur_slot <= nxt_slot;
    end

    assign nxt_owner = owner_q[nxt_slot];

    for (genvar p = 0; p < PROD; p++) begin : g_prio
        assign prio_flat[p*PRIO_W +: PRIO_W] = prio_q[p];
    end

endmodule

// File: rtl/hub_arbiter.sv
module hub_arbiter #(
    parameter int PROD   = 8,
    parameter int PW     = 3,
    parameter int PRIO_W = 4
) (
    input  logic [PROD-1:0]        req,
    input  logic [PW-1:0]          owner,
    input  logic [PROD*PRIO_W-1:0] prio_flat,
    output logic                   gnt_valid,
    output logic [PW-1:0]          gnt_idx
);

    logic [PRIO_W-1:0] best;

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        best      = '0;
        if (req[owner]) begin
            gnt_valid = 1'b1;
            gnt_idx   = owner;
        end else begin
            for (int i = 0; i < PROD; i++) begin
                if (req[i] && (!gnt_valid || prio_flat[i*PRIO_W +: PRIO_W] > best)) begin
                    gnt_valid = 1'b1;
                    gnt_idx   = PW'(i);
                    best      = prio_flat[i*PRIO_W +: PRIO_W];
                end
            end
        end
    end

endmodule

// File: rtl/hub_xbar.sv
module hub_xbar
    import hub_pkg::*;
#(
    parameter int ROUTERS = 4,
    parameter int FLIT_W  = 32,
    parameter int RW      = 2
) (
    input  logic                      route_en,
    input  logic [RW-1:0]             src_router,
    input  logic [DEST_W-1:0]         dest,
    input  logic [ROUTERS*FLIT_W-1:0] in_data,
    output logic [ROUTERS*FLIT_W-1:0] out_data,
    output logic [ROUTERS-1:0]        tx_active
);

    logic [FLIT_W-1:0] src_flit;

    assign src_flit = in_data[int'(src_router)*FLIT_W +: FLIT_W];

    for (genvar r = 0; r < ROUTERS; r++) begin : g_port
        logic hit;
        assign hit = route_en && (dest == DEST_BCAST || int'(dest) == r);
        assign tx_active[r] = hit;
        assign out_data[r*FLIT_W +: FLIT_W] = hit ? src_flit : '0;
    end

endmodule

// File: rtl/hub_top.sv
module hub_top
    import hub_pkg::*;
#(
    parameter int ROUTERS       = 4,
    parameter int NI_PER_ROUTER = 2,
    parameter int FLIT_W        = 32,
    parameter int FLITS_PER_PKT = 3,
    parameter int CYC_PER_FLIT  = 1,
    parameter int MAX_SLOTS     = 96,
    parameter int PRIO_W        = 4,
    parameter int CFG_AW        = 7,
    parameter int CFG_DW        = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [1:0]                        cfg_kind,
    input  logic [CFG_AW-1:0]                 cfg_addr,
    input  logic [CFG_DW-1:0]                 cfg_data,
    input  logic [ROUTERS*NI_PER_ROUTER-1:0]  req_i,
    output logic [ROUTERS*NI_PER_ROUTER-1:0]  access_o,
    input  logic [ROUTERS*FLIT_W-1:0]         in_data_i,
    output logic [ROUTERS*FLIT_W-1:0]         out_data_o,
    output logic [ROUTERS-1:0]                tx_active_o
);

    localparam int PROD     = ROUTERS * NI_PER_ROUTER;
    localparam int PW       = (PROD > 1) ? $clog2(PROD) : 1;
    localparam int RW       = (ROUTERS > 1) ? $clog2(ROUTERS) : 1;
    localparam int SLOT_LEN = FLITS_PER_PKT * CYC_PER_FLIT;
    localparam int PH_W     = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
    localparam int SLOT_AW  = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;
    localparam int CNT_W    = $clog2(MAX_SLOTS + 1);
    localparam int HDR_LSB  = FLIT_W - DEST_W;

    hub_state_e            state_q, state_d;
    logic [PH_W-1:0]       phase_q;
    logic [PW-1:0]         gnt_idx_q;
    logic [DEST_W-1:0]     dest_q;
    logic [PW-1:0]         nxt_owner;
    logic [PROD*PRIO_W-1:0] prio_flat;
    logic                  arb_valid;
    logic [PW-1:0]         arb_idx;
    logic                  phase_last;
    logic [RW-1:0]         src_router;
    logic [DEST_W-1:0]     live_dest;
    logic [DEST_W-1:0]     route_dest;
    logic                  route_en;

    assign phase_last = (phase_q == PH_W'(SLOT_LEN - 1));
    assign src_router = RW'(gnt_idx_q / PW'(NI_PER_ROUTER));
    assign live_dest  = in_data_i[int'(src_router)*FLIT_W + HDR_LSB +: DEST_W];

    hub_sched #(
        .PROD(PROD), .PW(PW), .PRIO_W(PRIO_W), .MAX_SLOTS(MAX_SLOTS),
        .SLOT_AW(SLOT_AW), .CNT_W(CNT_W), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
    ) u_sched (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .advance(phase_last),
        .nxt_owner(nxt_owner), .prio_flat(prio_flat)
    );

    hub_arbiter #(.PROD(PROD), .PW(PW), .PRIO_W(PRIO_W)) u_arb (
        .req(req_i), .owner(nxt_owner), .prio_flat(prio_flat),
        .gnt_valid(arb_valid), .gnt_idx(arb_idx)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (phase_last) state_d = arb_valid ? ST_HEAD : ST_IDLE;
            end
            ST_HEAD: begin
                if (phase_last)
                    state_d = arb_valid ? ST_HEAD : ST_IDLE;
                else if (phase_q == PH_W'(CYC_PER_FLIT - 1))
                    state_d = ST_PAYLOAD;
            end
            ST_PAYLOAD: begin
                if (phase_last) state_d = arb_valid ? ST_HEAD : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            phase_q   <= PH_W'(SLOT_LEN - 1);
            gnt_idx_q <= '0;
            dest_q    <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_last ? '0 : phase_q + 1'b1;
            if (phase_last && arb_valid) gnt_idx_q <= arb_idx;
            if (state_q == ST_HEAD)      dest_q    <= live_dest;
        end
    end

    // outputs
    always_comb begin
        access_o   = '0;
        route_en   = 1'b0;
        route_dest = dest_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_HEAD: begin
                access_o[gnt_idx_q] = 1'b1;
                route_en            = 1'b1;
                route_dest          = live_dest;
            end
            ST_PAYLOAD: begin
                access_o[gnt_idx_q] = 1'b1;
                route_en            = 1'b1;
            end
            default: ;
        endcase
    end

    hub_xbar #(.ROUTERS(ROUTERS), .FLIT_W(FLIT_W), .RW(RW)) u_xbar (
        .route_en(route_en), .src_router(src_router), .dest(route_dest),
        .in_data(in_data_i), .out_data(out_data_o), .tx_active(tx_active_o)
    );

endmodule

// File: rtl/hub_top_chk.sv
module hub_top_chk #(
    parameter int PROD     = 8,
    parameter int ROUTERS  = 4,
    parameter int SLOT_LEN = 3,
    parameter int PH_W     = 2,
    parameter int PW       = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [PROD-1:0]     req_i,
    input logic [PROD-1:0]     access_o,
    input logic [ROUTERS-1:0]  tx_active_o,
    input logic [PH_W-1:0]     phase_q,
    input logic [PW-1:0]       nxt_owner
);

    assert_access_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(access_o));

    assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == '0 && access_o != '0) |-> (($past(req_i) & access_o) != '0));

    assert_no_preempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_W'(SLOT_LEN - 1)) |=> $stable(access_o));

    assert_owner_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_W'(SLOT_LEN - 1) && req_i[nxt_owner]) |=> access_o[$past(nxt_owner)]);

    assert_tx_needs_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active_o != '0) |-> (access_o != '0));

    assert_path_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active_o != '0 && phase_q != PH_W'(SLOT_LEN - 1)) |=> $stable(tx_active_o));

endmodule

bind hub_top hub_top_chk #(
    .PROD(ROUTERS * NI_PER_ROUTER), .ROUTERS(ROUTERS),
    .SLOT_LEN(FLITS_PER_PKT * CYC_PER_FLIT), .PH_W(PH_W), .PW(PW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .access_o(access_o),
    .tx_active_o(tx_active_o), .phase_q(phase_q), .nxt_owner(nxt_owner)
);

// File: tb/test_hub_top.sv
module test_hub_top;

    localparam int R = 4, N = 2, P = 8, FW = 32, L = 3, MAXS = 96;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cfg_we;
    logic [1:0]      cfg_kind;
    logic [6:0]      cfg_addr;
    logic [7:0]      cfg_data;
    logic [P-1:0]    req_i;
    logic [P-1:0]    access_o;
    logic [R*FW-1:0] in_data_i;
    logic [R*FW-1:0] out_data_o;
    logic [R-1:0]    tx_active_o;

    always #4 clk = ~clk;

    hub_top i_hub_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .req_i(req_i),
        .access_o(access_o), .in_data_i(in_data_i), .out_data_o(out_data_o),
        .tx_active_o(tx_active_o)
    );

    int    checks = 0, failures = 0;
    bit    finished = 0;
    int    owner_m [MAXS];
    int    prio_m  [P];
    int    cnt_m;
    int    b_phase, b_slot, b_gp, cyc;
    bit    b_gv;
    logic [7:0] b_dest;
    string b_why, tag_ovr;
    int    pending [P];
    int    rise_c  [P];
    bit    waiting [P];
    bit    bound_on;

    function automatic int own_of(int s);
        int m;
        m = s % 8;
        if (s % 4 == 0) return 0;
        if (m >= 1 && m <= 3) return m;
        if (m == 5) return 4;
        if (m == 6) return 5;
        return (s % 16 == 7) ? 6 : 7;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic add_pkt(input int p);
        if (pending[p] < 3) begin
            if (pending[p] == 0) begin
                rise_c[p]  = cyc;
                waiting[p] = 1'b1;
            end
            pending[p]++;
        end
    endtask

    function automatic logic [7:0] pick_dest();
        case ($urandom % 6)
            0: return 8'd0;
            1: return 8'd1;
            2: return 8'd2;
            3: return 8'd3;
            4: return 8'hFF;
            default: return 8'h2A;
        endcase
    endfunction

    task automatic step();
        logic [P-1:0]  exp_acc;
        logic [R-1:0]  mask;
        logic [FW-1:0] src_flit;
        int            best, o, sch, wt, bnd;
        for (int p = 0; p < P; p++) req_i[p] = (pending[p] > 0);
        for (int r = 0; r < R; r++) in_data_i[r*FW +: FW] = $urandom;
        if (b_gv && b_phase == 0) in_data_i[(b_gp/N)*FW +: FW] = {b_dest, 24'($urandom)};
        #1;
        exp_acc = b_gv ? (P'(1) << b_gp) : '0;
        mask = '0;
        if (b_gv) begin
            if (b_dest == 8'hFF) mask = '1;
            else if (b_dest < 8'(R)) mask = R'(1) << b_dest;
        end
        src_flit = b_gv ? in_data_i[(b_gp/N)*FW +: FW] : '0;
        chk(access_o == exp_acc, (b_phase == 0 || !b_gv) ? b_why : "R5", 32'(access_o), 32'(exp_acc));
        chk(tx_active_o == mask, (b_dest == 8'hFF || b_dest >= 8'(R)) ? "R8" : "R7",
            32'(tx_active_o), 32'(mask));
        for (int r = 0; r < R; r++)
            chk(out_data_o[r*FW +: FW] == (mask[r] ? src_flit : '0), "R6",
                out_data_o[r*FW +: FW], mask[r] ? src_flit : '0);
        @(posedge clk);
        if (b_phase == L - 1) begin
            b_slot = (b_slot + 1 >= cnt_m) ? 0 : b_slot + 1;
            o = owner_m[b_slot];
            b_gv = 1'b0;
            if (pending[o] > 0) begin
                b_gp = o; b_gv = 1'b1; b_why = "R3";
            end else begin
                best = -1;
                for (int i = 0; i < P; i++)
                    if (pending[i] > 0 && (best < 0 || prio_m[i] > prio_m[best])) best = i;
                if (best >= 0) begin
                    b_gp = best; b_gv = 1'b1; b_why = "R4";
                end
            end
            if (b_gv) begin
                pending[b_gp]--;
                b_dest = pick_dest();
                if (waiting[b_gp] && bound_on) begin
                    sch = 0;
                    for (int s = 0; s < cnt_m; s++) if (owner_m[s] == b_gp) sch++;
                    if (sch > 0) begin
                        wt  = cyc + 1 - rise_c[b_gp];
                        bnd = ((cnt_m - 1) / sch + 1) * L + 1;
                        chk(wt <= bnd, "R10", 32'(wt), 32'(bnd));
                    end
                end
                waiting[b_gp] = 1'b0;
            end else begin
                b_why = "R2";
            end
            if (tag_ovr != "") b_why = tag_ovr;
            b_phase = 0;
        end else begin
            b_phase++;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [1:0] k, input int a, input int d);
        cfg_we = 1'b1; cfg_kind = k; cfg_addr = 7'(a); cfg_data = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reset_config(input int count);
        @(negedge clk);
        rst_n = 1'b0;
        req_i = '1;
        in_data_i = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        #1;
        chk(access_o == '0, "R1", 32'(access_o), 0);
        chk(tx_active_o == '0, "R1", 32'(tx_active_o), 0);
        chk(out_data_o == '0, "R1", out_data_o[31:0], 0);
        @(negedge clk);
        cnt_m = count;
        for (int s = 0; s < count; s++) begin
            owner_m[s] = own_of(s);
            cfg_wr(2'd0, s, owner_m[s]);
        end
        for (int p = 0; p < P; p++) cfg_wr(2'd1, p, prio_m[p]);
        cfg_wr(2'd2, 0, count);
        repeat (2) @(negedge clk);
        b_phase = L - 1; b_slot = cnt_m - 1; b_gv = 1'b0; b_why = "R1";
        for (int p = 0; p < P; p++) begin
            pending[p] = 0; waiting[p] = 1'b0;
        end
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_kind = '0; cfg_addr = '0; cfg_data = '0;
        req_i = '0; in_data_i = '0; cyc = 0; tag_ovr = ""; b_dest = '0; b_gp = 0;
        prio_m = '{9, 3, 5, 5, 1, 7, 7, 0};
        bound_on = 1'b1;
        reset_config(16);
        // contention among non-owners, ties and owner slots
        add_pkt(2); add_pkt(2); add_pkt(3); add_pkt(1);
        repeat (60) step();
        for (int p = 0; p < P; p++) begin add_pkt(p); add_pkt(p); add_pkt(p); end
        repeat (150) step();
        for (int k = 0; k < 3; k++) add_pkt(7);
        repeat (60) step();
        repeat (1500) begin
            if ($urandom % 8 == 0) add_pkt(int'($urandom % P));
            step();
        end
        // R9: writes while running must be ignored
        tag_ovr = "R9";
        cfg_we = 1'b1; cfg_kind = 2'd0; cfg_addr = 7'd0; cfg_data = 8'd7;
        step();
        cfg_kind = 2'd2; cfg_data = 8'd3;
        step();
        cfg_we = 1'b0;
        for (int p = 0; p < P; p++) add_pkt(p);
        repeat (90) begin
            if ($urandom % 6 == 0) add_pkt(int'($urandom % P));
            step();
        end
        // R9: shorter slot count, wrap point
        bound_on = 1'b0;
        reset_config(5);
        repeat (600) begin
            if ($urandom % 5 == 0) add_pkt(int'($urandom % P));
            step();
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule